// File: doc/BRIEF.md
# Nonvolatile Memory Write-Permission Gate

This block decides, once per write transaction, whether the data that follows the address phase may be stored. It sits beside the serial-bus slave of a small byte-wide nonvolatile memory. It holds the settings word that configures the protection, and it holds the lock of a 32-byte page that can be programmed only once. The bus front end gives it three things: a strobe when the address phase completes, with the target, the select byte and the 16-bit start address; the level of the two protection pins; and a commit strobe when a write transaction ends with data. The gate answers with a registered permit flag. It also exposes the settings word so that it can be read back.

Three protection sources act together. The first is a write-protect pin whose active level the settings word selects. The second is a read-only window that starts at array address zero and covers a binary fraction of the array. The third is the one-time lock of the special page. The settings word protects itself through a second pin once its own self-protect bit is set. Nonvolatile state is modelled as registers that reset to the factory defaults.

Top module: `nvm_wgate`

## Requirements
- R1: After reset the settings word reads 0x00, permit is 0, and the one-time page is unlocked.
- R2: In the settings word, bit 7 is the self-protect enable, bit 6 is the pin polarity, and bits 4..2 are the read-only size code. A committed settings write stores those bits from `wrData`. Bits 5, 1 and 0 always read back 0.
- R3: Writes to the array (target 0) and to the one-time page (target 1) are refused when `wpPin` differs from the polarity bit. They are otherwise allowed, subject to R5, R7 and R8.
- R4: A settings write (target 2) is permitted when the self-protect bit is 0, or when `crLockPin` is 1. Otherwise it is refused.
- R5: With size code c, where c is 1 to 6, array addresses below 4096>>(7-c) (64, 128 … 2048) are read-only. Code 7 makes all 4096 addresses read-only, and code 0 none. Only the low 12 address bits count.
- R6: The read-only window refuses array writes whatever the pin states. Settings writes follow only R4, whatever the window and `wpPin` are.
- R7: A one-time page write requires the select byte to be exactly 0xA2 and address bits 11..0 to be zero. Address bits 15..12 are ignored.
- R8: The first committed, permitted one-time page write sets the lock. Every later page request is then refused.
- R9: A page write refused by the pin (R3) does not set the lock.
- R10: Permit is sampled on `reqValid` and shows one cycle later. It holds through pin changes until the next `reqValid`, and it drops to 0 in the cycle after `commitValid`. Target 3 is always refused.
- R11: A commit whose permit was 0 changes neither the settings word nor the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset to factory defaults |
| wpPin | input | 1 | Write-protect pin, active level chosen by settings bit 6 |
| crLockPin | input | 1 | Pin that unlocks settings writes when self-protect is set |
| reqValid | input | 1 | Address phase complete; decision taken this cycle |
| reqTarget | input | 2 | 0 array, 1 one-time page, 2 settings word, 3 reserved |
| reqSel | input | 8 | Select byte of the transaction |
| reqAddr | input | 16 | Start address of the transaction |
| commitValid | input | 1 | Write transaction ended with data |
| wrData | input | 8 | Value for a settings write, valid with commitValid |
| permit | output | 1 | Registered write permission for the current transaction |
| ctrlReg | output | 8 | Current settings word |

## Verification
The hardest case to reach is the one-time page: it allows exactly one successful program per reset. Stimulus therefore spends the unlocked page on directed cases first. These are a pin-refused attempt that must leave it unlocked, wrong select and address patterns, and a pin toggled mid-transaction. Only after those does one commit set the lock. A seeded random phase then mixes settings rewrites, pin levels and addresses biased toward window edges and the page's exact select pattern.

// File: rtl/wgate_pkg.sv
package wgate_pkg;
  localparam int ADDR_W = 12;
  localparam int REQ_ADDR_W = 16;
  localparam int CODE_W = 3;
  localparam int POS_SELF = 7;
  localparam int POS_POL = 6;
  localparam int POS_CODE_LO = 2;
  localparam logic [7:0] PAGE_SEL = 8'hA2;
  localparam logic [7:0] CTRL_MASK = 8'hDC;

  typedef enum logic [1:0] {
    TGT_ARRAY = 2'd0,
    TGT_PAGE  = 2'd1,
    TGT_CTRL  = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  typedef struct packed {
    logic loadCtrl;
    logic setLock;
  } gate_strobe_t;
endpackage

// File: rtl/wgate_seq.sv
module wgate_seq
  import wgate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         commitValid,
  input  tgt_e         reqTarget,
  input  logic         rawPermit,
  output logic         permit,
  output gate_strobe_t strobe
);
  logic permitQ;
  tgt_e targetQ;
  logic commitNow;

  assign commitNow = commitValid && !reqValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      permitQ <= 1'b0;
      targetQ <= TGT_NONE;
    end else if (reqValid) begin
      permitQ <= rawPermit;
      targetQ <= reqTarget;
    end else if (commitValid) begin
      permitQ <= 1'b0;
      targetQ <= TGT_NONE;
    end
  end

  always_comb begin
    strobe.loadCtrl = commitNow && permitQ && (targetQ == TGT_CTRL);
    strobe.setLock  = commitNow && permitQ && (targetQ == TGT_PAGE);
  end

  assign permit = permitQ;
endmodule

// File: rtl/wgate_dp.sv
module wgate_dp
  import wgate_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  gate_strobe_t          strobe,
  input  logic [7:0]            wrData,
  input  logic                  wpPin,
  input  logic                  crLockPin,
  input  tgt_e                  reqTarget,
  input  logic [7:0]            reqSel,
  input  logic [REQ_ADDR_W-1:0] reqAddr,
  output logic                  rawPermit,
  output logic [7:0]            ctrlReg,
  output logic                  otpLock
);
  localparam int NCODES = 1 << CODE_W;

  logic [7:0]        ctrlQ;
  logic              lockQ;
  logic [ADDR_W-1:0] arrAddr;
  logic [CODE_W-1:0] sizeCode;
  logic [NCODES-1:0] hitVec;
  logic              wpActive;
  logic              roHit;
  logic              pageOk;
  logic              ctrlOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= 8'h00;
      lockQ <= 1'b0;
    end else begin
      if (strobe.loadCtrl) ctrlQ <= wrData & CTRL_MASK;
      if (strobe.setLock)  lockQ <= 1'b1;
    end
  end

  assign arrAddr  = reqAddr[ADDR_W-1:0];
  assign sizeCode = ctrlQ[POS_CODE_LO +: CODE_W];

  // one comparator per size code; window doubles with each code
  genvar c;
  generate
    for (c = 0; c < NCODES; c++) begin : g_win
      if (c == 0) begin : g_none
        assign hitVec[c] = 1'b0;
      end else if (c == NCODES - 1) begin : g_all
        assign hitVec[c] = 1'b1;
      end else begin : g_part
        localparam int SHIFT = ADDR_W - (NCODES - 1) + c;
        assign hitVec[c] = (arrAddr >> SHIFT) == '0;
      end
    end
  endgenerate

  assign roHit    = hitVec[sizeCode];
  assign wpActive = wpPin ^ ctrlQ[POS_POL];
  assign pageOk   = (reqSel == PAGE_SEL) && (arrAddr == '0) && !lockQ;
  assign ctrlOk   = !ctrlQ[POS_SELF] || crLockPin;

  always_comb begin
    unique case (reqTarget)
      TGT_ARRAY: rawPermit = !wpActive && !roHit;
      TGT_PAGE:  rawPermit = !wpActive && pageOk;
      TGT_CTRL:  rawPermit = ctrlOk;
      default:   rawPermit = 1'b0;
    endcase
  end

  assign ctrlReg = ctrlQ;
  assign otpLock = lockQ;
endmodule

// File: rtl/nvm_wgate.sv
module nvm_wgate
  import wgate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wpPin,
  input  logic        crLockPin,
  input  logic        reqValid,
  input  logic [1:0]  reqTarget,
  input  logic [7:0]  reqSel,
  input  logic [15:0] reqAddr,
  input  logic        commitValid,
  input  logic [7:0]  wrData,
  output logic        permit,
  output logic [7:0]  ctrlReg
);
  gate_strobe_t strobe;
  logic         rawPermit;
  logic         otpLock;
  tgt_e         tgt;

  assign tgt = tgt_e'(reqTarget);

  wgate_seq u_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .commitValid(commitValid),
    .reqTarget(tgt), .rawPermit(rawPermit), .permit(permit), .strobe(strobe)
  );

  wgate_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .wpPin(wpPin), .crLockPin(crLockPin), .reqTarget(tgt), .reqSel(reqSel),
    .reqAddr(reqAddr), .rawPermit(rawPermit), .ctrlReg(ctrlReg), .otpLock(otpLock)
  );
endmodule

// File: rtl/wgate_chk.sv
module wgate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        commitValid,
  input logic [1:0]  reqTarget,
  input logic [7:0]  reqSel,
  input logic [15:0] reqAddr,
  input logic        wpPin,
  input logic [7:0]  ctrlReg,
  input logic        permit,
  input logic        otpLock
);
  // R10
  permit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !commitValid) |=> $stable(permit));
  // R10
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && !reqValid) |=> !permit);
  // R2
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[5] == 1'b0) && (ctrlReg[1:0] == 2'b00));
  // R11
  ctrl_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commitValid |=> $stable(ctrlReg));
  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    otpLock |=> otpLock);
  // R3
  pin_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqTarget != 2'd2 && (wpPin ^ ctrlReg[6])) |=> !permit);
  // R7
  page_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqTarget == 2'd1 && (reqSel != 8'hA2 || reqAddr[11:0] != 12'h0)) |=> !permit);
  // R5
  full_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqTarget == 2'd0 && ctrlReg[4:2] == 3'd7) |=> !permit);
  // R8
  locked_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqTarget == 2'd1 && otpLock) |=> !permit);
endmodule

bind nvm_wgate wgate_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .commitValid(commitValid),
  .reqTarget(reqTarget), .reqSel(reqSel), .reqAddr(reqAddr), .wpPin(wpPin),
  .ctrlReg(ctrlReg), .permit(permit), .otpLock(otpLock)
);

// File: tb/sim_nvm_wgate.sv
`timescale 1ns/1ps
module sim_nvm_wgate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wpPin = 1'b0, crLockPin = 1'b0, reqValid = 1'b0, commitValid = 1'b0;
  logic [1:0] reqTarget = 2'd0;
  logic [7:0] reqSel = 8'h00, wrData = 8'h00;
  logic [15:0] reqAddr = 16'h0;
  logic permit;
  logic [7:0] ctrlReg;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] mCtrl = 8'h00;
  logic mLock = 1'b0;
  logic mPend = 1'b0;
  logic [1:0] mTgt = 2'd3;

  always #10 clk = ~clk;

  nvm_wgate u0 (
    .clk(clk), .rstN(rstN), .wpPin(wpPin), .crLockPin(crLockPin),
    .reqValid(reqValid), .reqTarget(reqTarget), .reqSel(reqSel), .reqAddr(reqAddr),
    .commitValid(commitValid), .wrData(wrData), .permit(permit), .ctrlReg(ctrlReg)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      report();
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic expPermit(input logic [1:0] t, input logic [7:0] s,
                                     input logic [15:0] a, input logic wc, input logic wcr);
    logic prot;
    int code, lim;
    prot = (wc != mCtrl[6]);
    code = int'(mCtrl[4:2]);
    lim = (code == 0) ? 0 : (code == 7) ? 4096 : (4096 >> (7 - code));
    case (t)
      2'd0: return !prot && (int'(a[11:0]) >= lim);
      2'd1: return !prot && !mLock && s == 8'hA2 && a[11:0] == 12'h000;
      2'd2: return !mCtrl[7] || wcr;
      default: return 1'b0;
    endcase
  endfunction

  task automatic doReq(input string req, input logic [1:0] t, input logic [7:0] s,
                       input logic [15:0] a, input logic wc, input logic wcr);
    @(negedge clk);
    reqTarget = t; reqSel = s; reqAddr = a; wpPin = wc; crLockPin = wcr; reqValid = 1'b1;
    mPend = expPermit(t, s, a, wc, wcr);
    mTgt = t;
    @(negedge clk);
    reqValid = 1'b0;
    check(req, {7'd0, permit}, {7'd0, mPend});
  endtask

  task automatic doCommit(input string req, input logic [7:0] d);
    @(negedge clk);
    commitValid = 1'b1; wrData = d;
    @(negedge clk);
    commitValid = 1'b0;
    if (mPend && mTgt == 2'd2) mCtrl = d & 8'hDC;
    if (mPend && mTgt == 2'd1) mLock = 1'b1;
    mPend = 1'b0;
    check(req, ctrlReg, mCtrl);
    check("R10 permit cleared", {7'd0, permit}, 8'd0);
  endtask

  task automatic setCtrl(input logic [7:0] d);
    doReq("R4 ctrl write", 2'd2, 8'h00, 16'h0, wpPin, 1'b1);
    doCommit("R2 ctrl store", d);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset ctrl", ctrlReg, 8'h00);
    check("R1 reset permit", {7'd0, permit}, 8'd0);
    rstN = 1'b1;
    doReq("R1 default array", 2'd0, 8'h00, 16'h0000, 1'b0, 1'b0);
    doReq("R3 pin high pol0", 2'd0, 8'h00, 16'h0100, 1'b1, 1'b0);
    setCtrl(8'h40);
    doReq("R3 pin high pol1", 2'd0, 8'h00, 16'h0100, 1'b1, 1'b0);
    doReq("R3 pin low pol1", 2'd0, 8'h00, 16'h0100, 1'b0, 1'b0);
    setCtrl(8'h27);
    check("R2 spare bits", ctrlReg, 8'h04);
    for (int c = 1; c < 8; c++) begin
      int lim;
      lim = (c == 7) ? 4096 : (4096 >> (7 - c));
      setCtrl(8'(c << 2));
      doReq("R5 inside window", 2'd0, 8'h00, 16'(lim - 1), 1'b0, 1'b0);
      if (c < 7) doReq("R5 window edge", 2'd0, 8'h00, 16'(lim), 1'b0, 1'b0);
      doReq("R6 ctrl free of window", 2'd2, 8'h00, 16'h0, 1'b1, 1'b0);
    end
    setCtrl(8'h04);
    doReq("R5 upper bits ignored", 2'd0, 8'h00, 16'hF010, 1'b0, 1'b0);
    doReq("R6 window vs pins", 2'd0, 8'h00, 16'h0000, 1'b0, 1'b1);
    setCtrl(8'h80);
    doReq("R4 self-protect pin low", 2'd2, 8'h00, 16'h0, 1'b0, 1'b0);
    doCommit("R11 refused ctrl commit", 8'h00);
    doReq("R4 self-protect pin high", 2'd2, 8'h00, 16'h0, 1'b0, 1'b1);
    doCommit("R4 ctrl cleared", 8'h00);
    doReq("R7 bad select", 2'd1, 8'hA3, 16'h0000, 1'b0, 1'b0);
    doReq("R7 bad low addr", 2'd1, 8'hA2, 16'h0001, 1'b0, 1'b0);
    doReq("R7 bad high nibble", 2'd1, 8'hA2, 16'h0100, 1'b0, 1'b0);
    doReq("R7 top nibble ignored", 2'd1, 8'hA2, 16'hF000, 1'b0, 1'b0);
    doReq("R9 pin blocks page", 2'd1, 8'hA2, 16'h0000, 1'b1, 1'b0);
    doCommit("R9 refused page commit", 8'h00);
    doReq("R9 page still open", 2'd1, 8'hA2, 16'h0000, 1'b0, 1'b0);
    wpPin = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 permit held", {7'd0, permit}, 8'd1);
    doCommit("R8 page commit", 8'h00);
    doReq("R8 page locked", 2'd1, 8'hA2, 16'h0000, 1'b0, 1'b0);
    doReq("R10 reserved target", 2'd3, 8'hA2, 16'h0000, 1'b0, 1'b1);
    for (int i = 0; i < 400; i++) begin
      logic [1:0] t;
      logic [7:0] s;
      logic [15:0] a;
      t = 2'($urandom_range(0, 3));
      s = ($urandom_range(0, 1) != 0) ? 8'hA2 : 8'($urandom);
      case ($urandom_range(0, 2))
        0: a = 16'h0;
        1: a = 16'(32'd1 << $urandom_range(5, 11));
        default: a = 16'($urandom);
      endcase
      doReq("R5 R3 random request", t, s, a, 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 2) != 0) doCommit("R11 random commit", 8'($urandom));
    end
    report();
  end
endmodule